// File: doc/BRIEF.md
# Ready-Flagged Serial ADC Host Reader

This block is the host side of a link to a slave-mode delta-sigma converter whose single data pin doubles as a "result ready" flag. While enabled it keeps the converter selected (chip select low) so conversions run back to back. It watches the shared data line, and a low level there means a fresh result is waiting. It then drives an idle-high serial clock for exactly 24 pulses, captures one bit on each rising edge with the most significant bit first, and presents the word on a parallel output with a one-cycle valid strobe.

The read can run as one unbroken train or as three 8-bit batches separated by a longer idle-high gap. The converter codes its result as offset binary. A mode input lets the block pass that code through unchanged or turn it into two's complement. A waiting-time counter flags an error when no ready indication arrives within a set number of cycles. Dropping the enable deselects the converter at once, which aborts any read in progress.

Top module: `adc_rdy_reader`

## Requirements
- R1: While reset or `en_i` is low, `cs_n_o` and `sclk_o` are both 1. One cycle after `en_i` rises, `cs_n_o` is 0. Dropping `en_i` during a read returns both to 1 on the next cycle, and no `valid_o` follows from that read.
- R2: A read starts only when `sdo_i` is low and has been seen high since chip select went low or since the previous read ended. A line that stays low after a read starts no new clock activity.
- R3: Each read produces exactly 24 falling and 24 rising edges on `sclk_o`. `sclk_o` rests at 1 between reads and whenever chip select is high.
- R4: Bits are captured on the rising edges of `sclk_o`, the first captured bit being bit 23 of the word and the last being bit 0.
- R5: Every low phase of `sclk_o` and every high phase between two bits of a read lasts exactly HALF_DIV system cycles. With the default of 25 at a 250 MHz clock, that is 100 ns.
- R6: With `batch_i` = 1, the high phase after the 8th and after the 16th rising edge lasts HALF_DIV + GAP_CYC cycles. With `batch_i` = 0, it lasts HALF_DIV cycles like the others.
- R7: With `twos_i` = 0, `word_o` equals the received offset-binary code. With `twos_i` = 1, bit 23 is inverted, so 0x800000 gives 0x000000, 0x000000 gives 0x800000 and 0xFFFFFF gives 0x7FFFFF.
- R8: `valid_o` is high for exactly one cycle per completed word, and `word_o` holds its value until the next `valid_o`.
- R9: While enabled and waiting, `timeout_o` pulses for one cycle after every TIMEOUT_CYC cycles without a read starting. It stays low while reads keep arriving sooner than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Keep the converter selected and read results |
| batch_i | input | 1 | 1: split each read into three 8-bit batches with gaps |
| twos_i | input | 1 | 1: output two's complement, 0: offset binary |
| cs_n_o | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| sdo_i | input | 1 | Shared data / ready line from the converter |
| word_o | output | 24 | Last received result |
| valid_o | output | 1 | One-cycle strobe with each new word |
| timeout_o | output | 1 | One-cycle pulse when the ready wait runs too long |

## Verification
On every cycle the assertions check the pin-level rules: the idle-high clock under deselect, the exact low and high phase lengths, the cap of 24 falling edges per read with a full count at each strobe, the single-cycle strobe, and a prompt deselect on disable. The bench's scenarios show the rest. It checks the captured bit order and the MSB inversion on directed extreme codes and on random words. It measures the batch gaps against the continuous case. It holds the data line low after a read to show that no second read starts. It also checks the timeout pulse count during a long silence and an aborted read that must produce no strobe.

// File: rtl/adc_rdy_pkg.sv
package adc_rdy_pkg;
  localparam int WORD_BITS  = 24;
  localparam int BATCH_BITS = 8;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } rd_state_t;
endpackage

// File: rtl/adc_rdy_sync.sv
module adc_rdy_sync #(
  parameter int STAGES = 2,
  parameter bit RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RESET_VAL}};
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/adc_rdy_timer.sv
module adc_rdy_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt;
  logic         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load_i) begin
      cnt  <= limit_i - 1'b1;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign expire_o = busy && (cnt == '0);
endmodule

// File: rtl/adc_rdy_shift.sv
module adc_rdy_shift #(
  parameter int BITS = 24,
  localparam int CW = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            shift_i,
  input  logic            bit_i,
  output logic [BITS-1:0] data_o,
  output logic [CW-1:0]   count_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      data_o  <= '0;
      count_o <= '0;
    end else if (shift_i) begin
      data_o  <= {data_o[BITS-2:0], bit_i};
      count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/adc_rdy_reader.sv
module adc_rdy_reader
  import adc_rdy_pkg::*;
#(
  parameter int HALF_DIV    = 25,
  parameter int GAP_CYC     = 64,
  parameter int TIMEOUT_CYC = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 batch_i,
  input  logic                 twos_i,
  output logic                 cs_n_o,
  output logic                 sclk_o,
  input  logic                 sdo_i,
  output logic [WORD_BITS-1:0] word_o,
  output logic                 valid_o,
  output logic                 timeout_o
);
  localparam int TMAX = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int TOW  = $clog2(TIMEOUT_CYC + 1);
  localparam int CW   = $clog2(WORD_BITS + 1);

  rd_state_t            state;
  logic                 sdo_s;
  logic                 armed;
  logic [TOW-1:0]       to_cnt;
  logic                 tmr_load, tmr_gap, tmr_exp;
  logic [TW-1:0]        tmr_limit;
  logic                 sh_clr, sh_shift, start_rd;
  logic [WORD_BITS-1:0] sh_data;
  logic [CW-1:0]        bit_cnt;
  logic                 word_done, batch_edge;

  adc_rdy_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d_i(sdo_i), .q_o(sdo_s)
  );

  adc_rdy_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load_i(tmr_load), .limit_i(tmr_limit), .expire_o(tmr_exp)
  );

  adc_rdy_shift #(.BITS(WORD_BITS)) u_shift (
    .clk(clk), .rst(rst), .clr_i(sh_clr), .shift_i(sh_shift), .bit_i(sdo_s),
    .data_o(sh_data), .count_o(bit_cnt)
  );

  assign word_done  = (bit_cnt == CW'(WORD_BITS));
  assign batch_edge = batch_i && (bit_cnt != '0) &&
                      ((bit_cnt & CW'(BATCH_BITS - 1)) == '0);
  assign tmr_limit  = tmr_gap ? TW'(GAP_CYC) : TW'(HALF_DIV);

  // Control strobes for the timer and the shift register
  always_comb begin
    tmr_load = 1'b0;
    tmr_gap  = 1'b0;
    sh_clr   = 1'b0;
    sh_shift = 1'b0;
    start_rd = 1'b0;
    if (en_i) begin
      case (state)
        ST_WAIT: if (armed && !sdo_s) begin
          start_rd = 1'b1;
          tmr_load = 1'b1;
          sh_clr   = 1'b1;
        end
        ST_LOW: if (tmr_exp) begin
          tmr_load = 1'b1;
          sh_shift = 1'b1;
        end
        ST_HIGH: if (tmr_exp && !word_done) begin
          tmr_load = 1'b1;
          tmr_gap  = batch_edge;
        end
        ST_GAP: if (tmr_exp) tmr_load = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      cs_n_o    <= 1'b1;
      sclk_o    <= 1'b1;
      armed     <= 1'b0;
      valid_o   <= 1'b0;
      word_o    <= '0;
      to_cnt    <= '0;
      timeout_o <= 1'b0;
    end else begin
      valid_o   <= 1'b0;
      timeout_o <= 1'b0;
      if (!en_i) begin
        state  <= ST_OFF;
        cs_n_o <= 1'b1;
        sclk_o <= 1'b1;
        armed  <= 1'b0;
        to_cnt <= '0;
      end else begin
        case (state)
          ST_OFF: begin
            cs_n_o <= 1'b0;
            armed  <= 1'b0;
            to_cnt <= '0;
            state  <= ST_WAIT;
          end
          ST_WAIT: begin
            if (sdo_s) armed <= 1'b1;
            if (start_rd) begin
              sclk_o <= 1'b0;
              armed  <= 1'b0;
              to_cnt <= '0;
              state  <= ST_LOW;
            end else if (to_cnt == TOW'(TIMEOUT_CYC - 1)) begin
              to_cnt    <= '0;
              timeout_o <= 1'b1;
            end else begin
              to_cnt <= to_cnt + 1'b1;
            end
          end
          ST_LOW: if (tmr_exp) begin
            sclk_o <= 1'b1;
            state  <= ST_HIGH;
          end
          ST_HIGH: if (tmr_exp) begin
            if (word_done) begin
              valid_o <= 1'b1;
              word_o  <= twos_i ? {~sh_data[WORD_BITS-1], sh_data[WORD_BITS-2:0]}
                                : sh_data;
              state   <= ST_WAIT;
            end else if (batch_edge) begin
              state <= ST_GAP;
            end else begin
              sclk_o <= 1'b0;
              state  <= ST_LOW;
            end
          end
          ST_GAP: if (tmr_exp) begin
            sclk_o <= 1'b0;
            state  <= ST_LOW;
          end
          default: state <= ST_OFF;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_rdy_reader_chk.sv
module adc_rdy_reader_chk #(
  parameter int HALF_DIV = 25
) (
  input logic clk,
  input logic rst,
  input logic en_i,
  input logic cs_n_o,
  input logic sclk_o,
  input logic valid_o,
  input logic timeout_o
);
  localparam int LW = $clog2(HALF_DIV + 1);

  logic [LW-1:0] low_len, high_len;
  logic [5:0]    fall_cnt;
  logic          sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_len  <= '0;
      high_len <= LW'(HALF_DIV);
      fall_cnt <= '0;
      sclk_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o) low_len <= '0;
      else if (low_len != LW'(HALF_DIV)) low_len <= low_len + 1'b1;
      if (!sclk_o) high_len <= '0;
      else if (high_len != LW'(HALF_DIV)) high_len <= high_len + 1'b1;
      if (cs_n_o || valid_o) fall_cnt <= '0;
      else if (sclk_d && !sclk_o) fall_cnt <= fall_cnt + 1'b1;
    end
  end

  assert_deselect_R1: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cs_n_o && sclk_o));

  assert_idle_high_R3: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> sclk_o);

  assert_max_falls_R3: assert property (@(posedge clk) disable iff (rst)
    fall_cnt <= 6'd24);

  assert_full_word_R3: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (fall_cnt == 6'd24));

  assert_low_phase_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(sclk_o) && !cs_n_o) |-> (low_len == LW'(HALF_DIV)));

  assert_high_phase_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_o) |-> (high_len == LW'(HALF_DIV)));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_timeout_idle_R9: assert property (@(posedge clk) disable iff (rst)
    timeout_o |-> (sclk_o && !cs_n_o));
endmodule

bind adc_rdy_reader adc_rdy_reader_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
  .valid_o(valid_o), .timeout_o(timeout_o)
);

// File: tb/adc_rdy_reader_tb.sv
`timescale 1ns/1ps
module adc_rdy_reader_tb;
  localparam int HALF = 25;
  localparam int GAP  = 64;
  localparam int TOC  = 2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, batch = 1'b0, twos = 1'b0;
  logic sdo_q = 1'b1;
  logic cs_n, sclk, valid, tmo;
  logic [23:0] word;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  adc_rdy_reader #(.HALF_DIV(HALF), .GAP_CYC(GAP), .TIMEOUT_CYC(TOC)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .batch_i(batch), .twos_i(twos),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdo_i(sdo_q), .word_o(word),
    .valid_o(valid), .timeout_o(tmo)
  );

  // Pin monitor: phase lengths, edge counts, strobes
  int rises = 0, lo_run = 0, hi_run = 0, lo_min = 9999, hi_min = 9999;
  int h8 = 0, h16 = 0;
  int s_rises = 0, s_lo_min = 0, s_hi_min = 0, s_h8 = 0, s_h16 = 0;
  int valid_total = 0, tmo_total = 0;
  logic sclk_prev = 1'b1;

  always @(negedge clk) begin
    if (valid) valid_total++;
    if (tmo) tmo_total++;
    if (cs_n) begin
      rises = 0; lo_run = 0; hi_run = 0; lo_min = 9999; hi_min = 9999;
    end else begin
      if (sclk && !sclk_prev) begin
        if (lo_run < lo_min) lo_min = lo_run;
        rises++;
        hi_run = 0;
      end
      if (!sclk && sclk_prev) begin
        if (rises == 8) h8 = hi_run;
        else if (rises == 16) h16 = hi_run;
        else if (rises > 0 && hi_run < hi_min) hi_min = hi_run;
        lo_run = 0;
      end
      if (sclk) hi_run++; else lo_run++;
      if (valid) begin
        s_rises = rises; s_lo_min = lo_min; s_hi_min = hi_min;
        s_h8 = h8; s_h16 = h16;
        rises = 0; lo_min = 9999; hi_min = 9999;
      end
    end
    sclk_prev = sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(input logic [23:0] raw, input logic tc);
    return tc ? (raw ^ 24'h800000) : raw;
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Play the converter for one result and check what comes out
  task automatic serve(input logic [23:0] raw, input logic tc, input logic bt,
                       input int dly);
    logic [23:0] got;
    int guard;
    @(negedge clk);
    twos = tc; batch = bt; sdo_q = 1'b1;
    repeat (dly) @(negedge clk);
    sdo_q = 1'b0;
    for (int i = 0; i < 24; i++) begin
      @(negedge sclk);
      #1 sdo_q = raw[23 - i];
    end
    guard = 0;
    @(negedge clk);
    while (!valid && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    got = word;
    chk(valid, "R8", "strobe after word", int'(valid), 1);
    chk(got == exp_word(raw, tc), "R4/R7", "word value", int'(got), int'(exp_word(raw, tc)));
    @(negedge clk);
    chk(!valid, "R8", "strobe width", int'(valid), 0);
    chk(word == got, "R8", "word held", int'(word), int'(got));
    chk(s_rises == 24, "R3", "rising edges", s_rises, 24);
    chk(s_lo_min == HALF, "R5", "low phase", s_lo_min, HALF);
    chk(s_hi_min == HALF, "R5", "high phase", s_hi_min, HALF);
    chk(s_h8 == (bt ? HALF + GAP : HALF), "R6", "high after bit 8", s_h8,
        bt ? HALF + GAP : HALF);
    chk(s_h16 == (bt ? HALF + GAP : HALF), "R6", "high after bit 16", s_h16,
        bt ? HALF + GAP : HALF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=0 expected=1");
    finish_run();
  end

  initial begin
    int v0;
    int t0;
    bit quiet;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    chk(sclk == 1'b1, "R3", "sclk in reset", int'(sclk), 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n while disabled", int'(cs_n), 1);
    en = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b0, "R1", "cs_n after enable", int'(cs_n), 0);

    // Directed extreme codes
    serve(24'h800000, 1'b0, 1'b0, 200);
    serve(24'h800000, 1'b1, 1'b0, 150);
    serve(24'h000000, 1'b1, 1'b1, 150);
    serve(24'hFFFFFF, 1'b1, 1'b0, 150);
    serve(24'hFFFFFF, 1'b0, 1'b1, 150);
    serve(24'hA5C33C, 1'b0, 1'b1, 120);

    // R2: line left low after a read must not restart the clock
    serve(24'h123456, 1'b0, 1'b0, 120);
    sdo_q = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!sclk) quiet = 1'b0;
    end
    chk(quiet, "R2", "no re-read on held-low line", int'(quiet), 1);
    serve(24'h6BCDEF, 1'b1, 1'b0, 120);

    // Random words, modes and conversion delays
    for (int n = 0; n < 12; n++) begin
      serve(24'($urandom()), 1'($urandom() % 2), 1'($urandom() % 2),
            100 + int'($urandom() % 400));
    end
    chk(tmo_total == 0, "R9", "no timeout with regular results", tmo_total, 0);

    // R9: long silence
    t0 = tmo_total;
    sdo_q = 1'b1;
    repeat (4500) @(negedge clk);
    chk(tmo_total - t0 == 2, "R9", "timeout pulses in 4500 cycles", tmo_total - t0, 2);
    serve(24'h0F0F0F, 1'b0, 1'b0, 50);

    // R1: abort a read by disabling
    @(negedge clk);
    sdo_q = 1'b1;
    repeat (60) @(negedge clk);
    sdo_q = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge sclk);
      #1 sdo_q = 1'b1;
    end
    @(negedge clk);
    v0 = valid_total;
    en = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1", "deselect on disable",
        int'({cs_n, sclk}), 3);
    repeat (300) @(negedge clk);
    chk(valid_total == v0, "R1", "no strobe from aborted read", valid_total, v0);
    sdo_q = 1'b1;
    en = 1'b1;
    serve(24'hC0FFEE, 1'b1, 1'b1, 100);

    finish_run();
  end
endmodule